// File: doc/BRIEF.md
# Three-Slot Instruction Decode Steering

This unit sits between a queue of pre-sized instructions and the micro-op queue of a processor front end. Each instruction arrives with an opaque identifier and a count of the micro-ops it expands into. Every clock the unit looks at up to three instructions at the head of the queue. It hands them, strictly in order, to three decoder slots with unequal capacity. The first slot takes an instruction of up to four micro-ops. The second and third slots only take instructions that produce exactly one micro-op. The best sustained rate is therefore a four-op instruction followed by two single-op ones.

An instruction that needs more than four micro-ops is handed to a sequencer. The sequencer produces its micro-ops over several cycles, four at most per cycle. While it runs, nothing else is decoded. The micro-ops of a cycle leave on six ordered lanes, each tagged with its instruction identifier and its index inside that instruction. Nothing moves in a cycle when the downstream queue reports less free room than that cycle needs.

Top module: `decode_steer`

## Requirements
- R1: Reset leaves the sequencer idle: with no instruction offered, `out_vld` and `take` are both 0, even if a long instruction was in progress when reset arrived.
- R2: An instruction of 1 to 4 micro-ops at the head (`in_vld[0]`) goes to slot 0. Its micro-ops fill lanes 0 to count-1, with its identifier and indices 0 to count-1.
- R3: The second and third offered instructions are taken in the same cycle only when their count is exactly 1 and the one ahead of them was taken too. An instruction of count above 1 in position 1 or 2 waits, together with everything behind it.
- R4: Valid lanes are contiguous from lane 0. Slot 1's micro-op directly follows slot 0's micro-ops and slot 2's micro-op directly follows slot 1's. Across cycles, micro-ops leave in program order with no gap or repeat.
- R5: `take` (0 to 3) equals the number of instructions consumed from the head in that cycle.
- R6: A head instruction with a count above 4 is consumed alone (`take` = 1) and emits only indices 0 to 3 in that cycle, even when more instructions are offered.
- R7: In each following cycle the sequencer emits min(4, remaining) micro-ops with continuing indices and `take` = 0, until the count is used up. Normal steering resumes in the next cycle.
- R8: When `oq_space` is smaller than the micro-ops the cycle requires, the cycle emits nothing, consumes nothing and leaves the sequencer where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 3 | Head entries present, thermometer coded from bit 0 |
| in_cnt | input | 3*CW | Micro-op count per head entry, entry k in bits [k*CW +: CW], count at least 1 |
| in_id | input | 3*IDW | Identifier per head entry |
| oq_space | input | SW | Free entries in the micro-op queue |
| take | output | 2 | Instructions consumed this cycle |
| out_vld | output | 6 | Valid micro-op lanes |
| out_id | output | 6*IDW | Instruction identifier per lane |
| out_idx | output | 6*CW | Micro-op index within its instruction, per lane |

## Verification
Two things can fall in the same cycle: a sequencer burst, the last one in particular, and a downstream queue too full to accept it. A long head instruction can also meet single-op followers that are eligible yet must be held back. Random queue room from 0 to 8 and random offer depth are mixed with directed lengths 5, 8 and 15, so stalls land on the start, the middle and the final burst of long instructions. Each cycle the lanes and `take` are compared with a bench model. A running stream pointer also confirms that every micro-op of the program appears exactly once and in order, so a stall that loses or repeats a burst is caught.

// File: rtl/decode_steer.sv
module decode_steer #(
  parameter int IDW = 8,
  parameter int CW  = 4,
  parameter int SW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        in_vld,
  input  logic [3*CW-1:0]   in_cnt,
  input  logic [3*IDW-1:0]  in_id,
  input  logic [SW-1:0]     oq_space,
  output logic [1:0]        take,
  output logic [5:0]        out_vld,
  output logic [6*IDW-1:0]  out_id,
  output logic [6*CW-1:0]   out_idx
);
  localparam int LANES = 6;
  localparam int MAXC  = 4;

  logic           seq_on;
  logic [IDW-1:0] seq_id;
  logic [CW-1:0]  seq_nxt, seq_rem, seq_n;
  logic [CW-1:0]  c0, c1, c2;
  logic           long0, t1, t2, go;
  logic [CW:0]    need;

  assign c0 = in_cnt[0 +: CW];
  assign c1 = in_cnt[CW +: CW];
  assign c2 = in_cnt[2*CW +: CW];

  assign long0 = in_vld[0] && (c0 > CW'(MAXC));
  assign t1    = in_vld[0] && !long0 && in_vld[1] && (c1 == CW'(1));
  assign t2    = t1 && in_vld[2] && (c2 == CW'(1));
  assign seq_n = (seq_rem > CW'(MAXC)) ? CW'(MAXC) : seq_rem;

  assign need = seq_on    ? {1'b0, seq_n} :
                long0     ? (CW+1)'(MAXC) :
                in_vld[0] ? {1'b0, c0} + (CW+1)'(t1) + (CW+1)'(t2) :
                            '0;

  assign go   = (need != '0) && (32'(oq_space) >= 32'(need));
  assign take = (!seq_on && go) ? (long0 ? 2'd1 : 2'd1 + 2'(t1) + 2'(t2)) : 2'd0;

  always_comb begin
    out_vld = '0;
    out_id  = '0;
    out_idx = '0;
    for (int i = 0; i < LANES; i++) begin
      if (seq_on) begin
        if (i < int'(seq_n)) begin
          out_vld[i]             = go;
          out_id[i*IDW +: IDW]   = seq_id;
          out_idx[i*CW +: CW]    = seq_nxt + CW'(i);
        end
      end else if (long0) begin
        if (i < MAXC) begin
          out_vld[i]             = go;
          out_id[i*IDW +: IDW]   = in_id[0 +: IDW];
          out_idx[i*CW +: CW]    = CW'(i);
        end
      end else if (in_vld[0]) begin
        if (i < int'(c0)) begin
          out_vld[i]             = go;
          out_id[i*IDW +: IDW]   = in_id[0 +: IDW];
          out_idx[i*CW +: CW]    = CW'(i);
        end else if (t1 && i == int'(c0)) begin
          out_vld[i]             = go;
          out_id[i*IDW +: IDW]   = in_id[IDW +: IDW];
        end else if (t2 && i == int'(c0) + 1) begin
          out_vld[i]             = go;
          out_id[i*IDW +: IDW]   = in_id[2*IDW +: IDW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_on  <= 1'b0;
      seq_id  <= '0;
      seq_nxt <= '0;
      seq_rem <= '0;
    end else if (go) begin
      if (seq_on) begin
        seq_nxt <= seq_nxt + seq_n;
        seq_rem <= seq_rem - seq_n;
        if (seq_rem == seq_n) seq_on <= 1'b0;
      end else if (long0) begin
        seq_on  <= 1'b1;
        seq_id  <= in_id[0 +: IDW];
        seq_nxt <= CW'(MAXC);
        seq_rem <= c0 - CW'(MAXC);
      end
    end
  end
endmodule

// File: rtl/decode_steer_chk.sv
module decode_steer_chk #(
  parameter int IDW = 8,
  parameter int CW  = 4,
  parameter int SW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        in_vld,
  input logic [3*CW-1:0]   in_cnt,
  input logic [3*IDW-1:0]  in_id,
  input logic [SW-1:0]     oq_space,
  input logic [1:0]        take,
  input logic [5:0]        out_vld,
  input logic [6*IDW-1:0]  out_id,
  input logic [6*CW-1:0]   out_idx
);
  p_lanes_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((6'(out_vld + 6'd1)) & out_vld) == 6'd0);

  p_take_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(take) <= $countones(in_vld));

  p_new_inst_lane0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take != 2'd0 && out_vld[0]) |->
      (out_idx[0 +: CW] == '0 && out_id[0 +: IDW] == in_id[0 +: IDW]));

  p_slot1_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take >= 2'd2) |-> (in_cnt[CW +: CW] == CW'(1)));

  p_seq_blocks_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take == 2'd1 && in_cnt[0 +: CW] > CW'(4)) |=> (take == 2'd0));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld != 6'd0) |-> ($countones(out_vld) <= int'(oq_space)));
endmodule

bind decode_steer decode_steer_chk #(.IDW(IDW), .CW(CW), .SW(SW)) u_chk (.*);

// File: tb/test_decode_steer.sv
`timescale 1ns/1ps
module test_decode_steer;
  localparam int IDW = 8, CW = 4, SW = 4, NP = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] in_vld = '0;
  logic [3*CW-1:0] in_cnt = '0;
  logic [3*IDW-1:0] in_id = '0;
  logic [SW-1:0] oq_space = '0;
  logic [1:0] take;
  logic [5:0] out_vld;
  logic [6*IDW-1:0] out_id;
  logic [6*CW-1:0] out_idx;

  decode_steer #(.IDW(IDW), .CW(CW), .SW(SW)) i_decode_steer (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  int pcnt[NP];
  int pid[NP];
  int h = 0, avail = 0, space = 0;
  int m_on = 0, m_id = 0, m_nxt = 0, m_rem = 0;
  int etake, ecnt, elong;
  int eid[6], eidx[6];
  string ereq[6];
  int s_inst = 0, s_idx = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int f_min4(int v);
    return v > 4 ? 4 : v;
  endfunction

  task automatic compute_exp();
    etake = 0; ecnt = 0; elong = 0;
    if (m_on != 0) begin
      if (space >= f_min4(m_rem)) begin
        ecnt = f_min4(m_rem);
        for (int k = 0; k < ecnt; k++) begin eid[k] = m_id; eidx[k] = m_nxt + k; ereq[k] = "R7"; end
      end
    end else if (avail > 0) begin
      if (pcnt[h] > 4) begin
        if (space >= 4) begin
          etake = 1; ecnt = 4; elong = 1;
          for (int k = 0; k < 4; k++) begin eid[k] = pid[h]; eidx[k] = k; ereq[k] = "R6"; end
        end
      end else begin
        int n = 1;
        if (avail > 1 && pcnt[h+1] == 1) begin
          n = 2;
          if (avail > 2 && pcnt[h+2] == 1) n = 3;
        end
        if (space >= pcnt[h] + n - 1) begin
          etake = n; ecnt = pcnt[h] + n - 1;
          for (int k = 0; k < pcnt[h]; k++) begin eid[k] = pid[h]; eidx[k] = k; ereq[k] = "R2"; end
          for (int k = 1; k < n; k++) begin
            eid[pcnt[h]+k-1] = pid[h+k]; eidx[pcnt[h]+k-1] = 0; ereq[pcnt[h]+k-1] = "R3";
          end
        end
      end
    end
  endtask

  task automatic drive_cycle(int cyc);
    @(negedge clk);
    if (cyc < 40) begin
      avail = (NP - h) < 3 ? NP - h : 3;
      space = 15;
    end else begin
      avail = int'($urandom % 4);
      if (avail > NP - h) avail = NP - h;
      space = int'($urandom % 9);
    end
    in_vld = 3'((1 << avail) - 1);
    in_cnt = '0; in_id = '0;
    for (int k = 0; k < avail; k++) begin
      in_cnt[k*CW +: CW] = CW'(pcnt[h+k]);
      in_id[k*IDW +: IDW] = IDW'(pid[h+k]);
    end
    oq_space = SW'(space);
    #1;
    compute_exp();
    chk(int'(take) == etake, "R5 take", int'(take), etake);
    chk($countones(out_vld) == ecnt, ecnt == 0 ? "R8 stall" : "R4 lane count",
        $countones(out_vld), ecnt);
    chk(int'(out_vld) == (1 << ecnt) - 1, "R4 contiguous", int'(out_vld), (1 << ecnt) - 1);
    for (int k = 0; k < 6; k++) begin
      if (out_vld[k]) begin
        if (k < ecnt) begin
          chk(int'(out_id[k*IDW +: IDW]) == eid[k], ereq[k], int'(out_id[k*IDW +: IDW]), eid[k]);
          chk(int'(out_idx[k*CW +: CW]) == eidx[k], ereq[k], int'(out_idx[k*CW +: CW]), eidx[k]);
        end
        chk(int'(out_id[k*IDW +: IDW]) == pid[s_inst] && int'(out_idx[k*CW +: CW]) == s_idx,
            "R4 stream order", int'(out_idx[k*CW +: CW]), s_idx);
        s_idx++;
        if (s_idx >= pcnt[s_inst]) begin s_inst++; s_idx = 0; end
      end
    end
    @(posedge clk);
    if (m_on != 0) begin
      if (ecnt != 0) begin m_nxt += ecnt; m_rem -= ecnt; m_on = (m_rem != 0) ? 1 : 0; end
    end else if (elong != 0) begin
      m_on = 1; m_id = pid[h]; m_nxt = 4; m_rem = pcnt[h] - 4;
    end
    h += etake;
  endtask

  initial begin
    int dir[24] = '{4,1,1, 1,2,1, 1,1,1, 9,1,1, 5,1, 8, 1,3, 15, 2,2,1, 1,1,5};
    int cyc;
    void'($urandom(32'd1234));
    for (int i = 0; i < NP; i++) begin
      int r = int'($urandom % 100);
      pid[i] = (i * 37 + 5) & 255;
      if (i < 24) pcnt[i] = dir[i];
      else if (r < 70) pcnt[i] = 1;
      else if (r < 85) pcnt[i] = 2 + int'($urandom % 3);
      else pcnt[i] = 5 + int'($urandom % 11);
    end
    #1;
    chk(out_vld == 6'd0 && take == 2'd0, "R1 reset idle", int'(out_vld), 0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // start a long instruction, then reset in the middle of it (R1)
    @(negedge clk);
    in_vld = 3'b001; in_cnt = '0; in_cnt[0 +: CW] = CW'(15); in_id = '0; in_id[0 +: IDW] = 8'hAA;
    oq_space = SW'(15);
    @(posedge clk);
    @(negedge clk);
    in_vld = '0; rst_n = 1'b0;
    #1;
    chk(out_vld == 6'd0 && take == 2'd0, "R1 reset during sequencer", int'(out_vld), 0);
    @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(out_vld == 6'd0 && take == 2'd0, "R1 sequencer idle after reset", int'(out_vld), 0);
    cyc = 0;
    while ((h < NP || m_on != 0) && cyc < 20000) begin
      drive_cycle(cyc);
      cyc++;
    end
    chk(s_inst == NP, "R7 all micro-ops delivered", s_inst, NP);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", h, NP);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule